// File: doc/BRIEF.md
# Scalar Shift and Mask Unit

This block is the shift-and-mask functional unit of a scalar datapath. Each cycle it may accept one operation, chosen by a three-bit selector, together with two scalar operands (the destination operand and a partner operand), a register-supplied shift count and the six-bit immediate field of the instruction. One clock later it presents the result alongside a valid flag. Instruction decode, operand fetch and write-back lie outside it. The caller decides where the result goes.

It provides four kinds of operation. Single-operand shifts take their count from the immediate field. Double-operand shifts run across the concatenation of both operands and take their count from the shift-count register. The immediate field of a double shift also holds two three-bit register numbers: when either is zero, the partner operand or the count is replaced by a fixed value. The mask operations build ones masks or zeros masks from either end of the word. Depending on the form, the immediate field holds either the mask width or the word width minus the mask width.

All shifts are logical and fill with zeros. The unit is parameterised in data width and count width. The immediate field is always log2 of the data width in bits.

Top module: `scalar_shift_mask_unit`

## Requirements
- R1: Operation code 0 (immediate left) produces `si` shifted left by `jk` places, with zeros filling the vacated low bits.
- R2: Operation code 1 (immediate right) produces `si` shifted right by `jk` places, with zeros filling the vacated high bits.
- R3: Operation code 2 (double left) forms the 128-bit value with `si` in the upper half and the partner in the lower half, shifts it left by the count, and returns the upper 64 bits.
- R4: Operation code 3 (double right) forms the 128-bit value with the partner in the upper half and `si` in the lower half, shifts it right by the count, and returns the lower 64 bits.
- R5: In a double shift, when `jk[2:0]` is 0 the count is 1 and `ak` is not used. Otherwise the count is `ak`.
- R6: In a double shift, when `jk[5:3]` is 0 the partner is zero, so the result is a plain shift of `si` by the count. Otherwise the partner is `sj`.
- R7: A double-shift count of 128 or more gives a result of zero. With a zero partner (R6), any count of 64 or more also gives zero.
- R8: Operation code 4 (ones from the right) produces a mask whose low 64−`jk` bits are ones and whose other bits are zeros. `jk`=0 gives all ones, and `jk`=8'o77 (63) gives the value 1.
- R9: Operation code 5 (ones from the left) produces a mask whose top `jk` bits are ones and whose other bits are zeros. `jk`=0 gives zero.
- R10: Operation code 6 (zeros from the left) produces a mask whose top `jk` bits are zeros and whose other bits are ones. `jk`=0 gives all ones.
- R11: Operation code 7 (zeros from the right) produces a mask whose low 64−`jk` bits are zeros and whose other bits are ones. `jk`=0 gives zero.
- R12: `result` takes the value for an operation, and `out_valid` goes high, on the clock edge after the edge that sampled `in_valid` high. `out_valid` is low after any edge that sampled `in_valid` low, and `result` then keeps its value. Reset (active-low `rst_n`) clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 3 | Operation selector, codes 0 to 7 as in R1 to R11 |
| si | input | 64 | Destination operand, the one that is shifted |
| sj | input | 64 | Partner operand for double shifts |
| ak | input | 24 | Register shift count for double shifts |
| jk | input | 6 | Immediate field: count, mask code, or j/k register numbers |
| out_valid | output | 1 | `result` holds a new value |
| result | output | 64 | Registered result |

## Verification
The bench builds the unit with its default parameters: a 64-bit data width and a 24-bit count. With these values, every immediate code from 0 to 63 is reachable. So are counts either side of the 64 and 128 boundaries, and counts near the 24-bit maximum, which show that the upper count bits force a zero result rather than wrapping. Directed cases cover the j-zero and k-zero substitutions, the mask end codes 0 and 63, and idle gaps between operations. A long pseudo-random run then mixes all eight operations.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

   typedef enum logic [2:0] {
      SSM_SHL_IMM     = 3'd0,
      SSM_SHR_IMM     = 3'd1,
      SSM_SHL_DBL     = 3'd2,
      SSM_SHR_DBL     = 3'd3,
      SSM_ONES_RIGHT  = 3'd4,
      SSM_ONES_LEFT   = 3'd5,
      SSM_ZEROS_LEFT  = 3'd6,
      SSM_ZEROS_RIGHT = 3'd7
   } ssm_op_e;

   typedef enum logic {
      SSM_DIR_LEFT  = 1'b0,
      SSM_DIR_RIGHT = 1'b1
   } ssm_dir_e;

endpackage

// File: rtl/ssm_barrel.sv
// Logarithmic barrel shifter with zero fill; the direction is fixed by a
// parameter and picked with a generate branch in every stage.
module ssm_barrel #(
   parameter int W    = 64,
   parameter int SH_W = 6,
   parameter bit LEFT = 1'b1
) (
   input  logic [W-1:0]    din,
   input  logic [SH_W-1:0] amt,
   output logic [W-1:0]    dout
);

   if ((1 << SH_W) > W) begin : g_bad_width
      $error("ssm_barrel: shift range exceeds width");
   end

   logic [W-1:0] stage [SH_W+1];

   assign stage[0] = din;

   for (genvar s = 0; s < SH_W; s++) begin : g_stage
      localparam int DIST = 1 << s;
      logic [W-1:0] moved;
      if (LEFT) begin : g_left
         assign moved = {stage[s][W-DIST-1:0], {DIST{1'b0}}};
      end else begin : g_right
         assign moved = {{DIST{1'b0}}, stage[s][W-1:DIST]};
      end
      assign stage[s+1] = amt[s] ? moved : stage[s];
   end

   assign dout = stage[SH_W];

endmodule

// File: rtl/ssm_dbl_shift.sv
// Double-operand shift across a 2*DATA_W concatenation, with the j/k field
// substitutions and overflow to zero.
module ssm_dbl_shift
   import ssm_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int CNT_W  = 24,
   parameter int IMM_W  = 6
) (
   input  logic [DATA_W-1:0] si,
   input  logic [DATA_W-1:0] sj,
   input  logic [CNT_W-1:0]  ak,
   input  logic [IMM_W-1:0]  jk,
   input  ssm_dir_e          dir,
   output logic [DATA_W-1:0] dout
);

   localparam int WIDE_W  = 2 * DATA_W;
   localparam int DSH_W   = $clog2(WIDE_W);
   localparam int HALF_IM = IMM_W / 2;

   if (CNT_W <= DSH_W) begin : g_bad_cnt
      $error("ssm_dbl_shift: count width must exceed the wide shift range");
   end
   if ((IMM_W % 2) != 0) begin : g_bad_imm
      $error("ssm_dbl_shift: immediate field must split into j and k halves");
   end

   logic              j_zero;
   logic              k_zero;
   logic [CNT_W-1:0]  count;
   logic              overflow;
   logic [DATA_W-1:0] partner;
   logic [WIDE_W-1:0] left_in;
   logic [WIDE_W-1:0] right_in;
   logic [WIDE_W-1:0] left_out;
   logic [WIDE_W-1:0] right_out;
   logic [DATA_W-1:0] picked;

   assign j_zero   = (jk[IMM_W-1:HALF_IM] == '0);
   assign k_zero   = (jk[HALF_IM-1:0] == '0);
   assign count    = k_zero ? CNT_W'(1) : ak;
   assign overflow = |count[CNT_W-1:DSH_W];
   assign partner  = j_zero ? '0 : sj;
   assign left_in  = {si, partner};
   assign right_in = {partner, si};

   ssm_barrel #(.W(WIDE_W), .SH_W(DSH_W), .LEFT(1'b1)) u_left (
      .din  (left_in),
      .amt  (count[DSH_W-1:0]),
      .dout (left_out)
   );

   ssm_barrel #(.W(WIDE_W), .SH_W(DSH_W), .LEFT(1'b0)) u_right (
      .din  (right_in),
      .amt  (count[DSH_W-1:0]),
      .dout (right_out)
   );

   always_comb begin
      if (dir == SSM_DIR_LEFT) begin
         picked = left_out[WIDE_W-1:DATA_W];
      end else begin
         picked = right_out[DATA_W-1:0];
      end
   end

   assign dout = overflow ? '0 : picked;

endmodule

// File: rtl/ssm_mask_gen.sv
// Mask builder: one top-aligned ones mask of jk bits serves all four forms,
// since a low mask of (W - jk) ones is its complement.
module ssm_mask_gen #(
   parameter int DATA_W = 64,
   parameter int IMM_W  = 6
) (
   input  logic [IMM_W-1:0]  jk,
   output logic [DATA_W-1:0] top_ones,
   output logic [DATA_W-1:0] low_ones
);

   logic [DATA_W-1:0] shifted_fill;

   ssm_barrel #(.W(DATA_W), .SH_W(IMM_W), .LEFT(1'b0)) u_fill (
      .din  ({DATA_W{1'b1}}),
      .amt  (jk),
      .dout (shifted_fill)
   );

   assign low_ones = shifted_fill;
   assign top_ones = ~shifted_fill;

endmodule

// File: rtl/scalar_shift_mask_unit.sv
module scalar_shift_mask_unit
   import ssm_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int CNT_W  = 24,
   parameter int IMM_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] si,
   input  logic [DATA_W-1:0] sj,
   input  logic [CNT_W-1:0]  ak,
   input  logic [IMM_W-1:0]  jk,
   output logic              out_valid,
   output logic [DATA_W-1:0] result
);

   if ((1 << IMM_W) != DATA_W) begin : g_bad_data
      $error("scalar_shift_mask_unit: data width must be 2**IMM_W");
   end

   ssm_op_e           op_e;
   logic [DATA_W-1:0] imm_left;
   logic [DATA_W-1:0] imm_right;
   logic [DATA_W-1:0] dbl_res;
   logic [DATA_W-1:0] top_ones;
   logic [DATA_W-1:0] low_ones;
   logic [DATA_W-1:0] next_res;
   ssm_dir_e          dbl_dir;

   assign op_e    = ssm_op_e'(op);
   assign dbl_dir = (op_e == SSM_SHR_DBL) ? SSM_DIR_RIGHT : SSM_DIR_LEFT;

   ssm_barrel #(.W(DATA_W), .SH_W(IMM_W), .LEFT(1'b1)) u_imm_left (
      .din  (si),
      .amt  (jk),
      .dout (imm_left)
   );

   ssm_barrel #(.W(DATA_W), .SH_W(IMM_W), .LEFT(1'b0)) u_imm_right (
      .din  (si),
      .amt  (jk),
      .dout (imm_right)
   );

   ssm_dbl_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W), .IMM_W(IMM_W)) u_dbl (
      .si   (si),
      .sj   (sj),
      .ak   (ak),
      .jk   (jk),
      .dir  (dbl_dir),
      .dout (dbl_res)
   );

   ssm_mask_gen #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_mask (
      .jk       (jk),
      .top_ones (top_ones),
      .low_ones (low_ones)
   );

   always_comb begin
      unique case (op_e)
         SSM_SHL_IMM:     next_res = imm_left;
         SSM_SHR_IMM:     next_res = imm_right;
         SSM_SHL_DBL,
         SSM_SHR_DBL:     next_res = dbl_res;
         SSM_ONES_RIGHT,
         SSM_ZEROS_LEFT:  next_res = low_ones;
         SSM_ONES_LEFT,
         SSM_ZEROS_RIGHT: next_res = top_ones;
         default:         next_res = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= next_res;
         end
      end
   end

endmodule

// File: rtl/ssm_checker.sv
module ssm_checker #(
   parameter int DATA_W = 64,
   parameter int CNT_W  = 24,
   parameter int IMM_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [2:0]        op,
   input logic [CNT_W-1:0]  ak,
   input logic [IMM_W-1:0]  jk,
   input logic              out_valid,
   input logic [DATA_W-1:0] result
);

   localparam int HALF_IM = IMM_W / 2;

   logic dbl_op;
   logic big_count;

   assign dbl_op    = (op == 3'd2) || (op == 3'd3);
   assign big_count = (ak >= CNT_W'(2 * DATA_W)) && (jk[HALF_IM-1:0] != '0);

   // R12: a sampled operation yields a valid output next cycle
   a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R12: an idle cycle yields no valid output
   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R12: the result holds across idle cycles
   a_r12_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

   // R8: ones from the right with code 0 is all ones
   a_r8_full_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd4 && jk == '0) |=> (result == {DATA_W{1'b1}}));

   // R9: ones from the left with code 0 is zero
   a_r9_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd5 && jk == '0) |=> (result == '0));

   // R7: an oversized double-shift count gives zero
   a_r7_overflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dbl_op && big_count) |=> (result == '0));

endmodule

bind scalar_shift_mask_unit ssm_checker #(
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W),
   .IMM_W  (IMM_W)
) u_ssm_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op        (op),
   .ak        (ak),
   .jk        (jk),
   .out_valid (out_valid),
   .result    (result)
);

// File: tb/scalar_shift_mask_unit_test.sv
module scalar_shift_mask_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op = '0;
   logic [63:0] si = '0;
   logic [63:0] sj = '0;
   logic [23:0] ak = '0;
   logic [5:0]  jk = '0;
   logic        out_valid;
   logic [63:0] result;

   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;
   string cur_tag = "R12";

   always #4 clk = ~clk;

   scalar_shift_mask_unit uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .op        (op),
      .si        (si),
      .sj        (sj),
      .ak        (ak),
      .jk        (jk),
      .out_valid (out_valid),
      .result    (result)
   );

   function automatic logic [63:0] mask_low(int n);
      logic [63:0] m = '0;
      for (int i = 0; i < n && i < 64; i++) m[i] = 1'b1;
      return m;
   endfunction

   function automatic logic [63:0] mask_high(int n);
      logic [63:0] m = '0;
      for (int i = 0; i < n && i < 64; i++) m[63-i] = 1'b1;
      return m;
   endfunction

   function automatic logic [63:0] ref_calc(logic [2:0] o, logic [63:0] a,
                                            logic [63:0] b, logic [23:0] c,
                                            logic [5:0] f);
      int unsigned n;
      logic [63:0]  p;
      logic [127:0] w;
      n = (f[2:0] == 3'd0) ? 1 : int'(c);
      p = (f[5:3] == 3'd0) ? 64'd0 : b;
      case (o)
         3'd0: return a << f;
         3'd1: return a >> f;
         3'd2: begin
            if (n >= 128) return 64'd0;
            w = {a, p} << n;
            return w[127:64];
         end
         3'd3: begin
            if (n >= 128) return 64'd0;
            w = {p, a} >> n;
            return w[63:0];
         end
         3'd4: return mask_low(64 - int'(f));
         3'd5: return mask_high(int'(f));
         3'd6: return ~mask_high(int'(f));
         default: return ~mask_low(64 - int'(f));
      endcase
   endfunction

   logic [63:0] m_res = '0;
   logic        m_val = 1'b0;
   string       m_tag = "R12";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_res <= '0;
         m_val <= 1'b0;
         m_tag <= "R12";
      end else begin
         m_val <= in_valid;
         if (in_valid) begin
            m_res <= ref_calc(op, si, sj, ak, jk);
            m_tag <= cur_tag;
         end
      end
   end

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            check(out_valid == 1'b0 && result == 64'd0, "R12 reset",
                  {63'd0, out_valid} | result, 64'd0);
         end else begin
            check(out_valid == m_val, "R12 valid",
                  {63'd0, out_valid}, {63'd0, m_val});
            check(result == m_res, m_tag, result, m_res);
         end
      end
   end

   task automatic send(logic [2:0] o, logic [63:0] a, logic [63:0] b,
                       logic [23:0] c, logic [5:0] f, string tag);
      @(negedge clk);
      op = o; si = a; sj = b; ak = c; jk = f;
      cur_tag = tag;
      in_valid = 1'b1;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         si = ~si;
         jk = jk + 6'd1;
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL R12 watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [63:0] pat;
      pat = 64'h8123_4567_89AB_CDEF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      send(3'd0, 64'h8000_0000_0000_0001, 0, 0, 6'd1, "R1 shl by 1");
      send(3'd0, pat, 0, 0, 6'd63, "R1 shl by 63");
      send(3'd0, pat, 0, 0, 6'd0, "R1 shl by 0");
      send(3'd1, pat, 0, 0, 6'd4, "R2 shr by 4");
      send(3'd1, pat, 0, 0, 6'd63, "R2 shr by 63");
      idle(2);
      send(3'd2, pat, 64'hF000_0000_0000_000F, 24'd4, 6'o12, "R3 dbl left 4");
      send(3'd2, pat, 64'hF0F0_0000_0000_0000, 24'd64, 6'o11, "R3 dbl left 64");
      send(3'd2, pat, 64'hAAAA_5555_AAAA_5555, 24'd127, 6'o13, "R3 dbl left 127");
      send(3'd3, pat, 64'h0000_0000_0000_00FF, 24'd60, 6'o21, "R4 dbl right 60");
      send(3'd3, pat, 64'h1234_0000_0000_4321, 24'd64, 6'o21, "R4 dbl right 64");
      send(3'd3, pat, 64'hFFFF_FFFF_FFFF_FFFF, 24'd127, 6'o22, "R4 dbl right 127");
      send(3'd2, pat, 64'hFFFF_0000_0000_0000, 24'd100, 6'o10, "R5 k zero left");
      send(3'd3, pat, 64'h0000_0000_0000_0001, 24'd100, 6'o10, "R5 k zero right");
      send(3'd2, pat, 64'hFFFF_FFFF_FFFF_FFFF, 24'd3, 6'o02, "R6 j zero left");
      send(3'd3, pat, 64'hFFFF_FFFF_FFFF_FFFF, 24'd3, 6'o02, "R6 j zero right");
      send(3'd2, pat, 64'hFFFF, 24'd128, 6'o11, "R7 left 128");
      send(3'd3, pat, 64'hFFFF, 24'd200, 6'o11, "R7 right 200");
      send(3'd2, pat, 64'hFFFF, 24'hFF_FFFF, 6'o11, "R7 left max count");
      send(3'd3, pat, 64'hFFFF, 24'h00_0140, 6'o11, "R7 right upper bit");
      send(3'd2, pat, 64'hFFFF, 24'd64, 6'o01, "R7 j zero left 64");
      send(3'd3, pat, 64'hFFFF, 24'd64, 6'o01, "R7 j zero right 64");
      idle(1);
      send(3'd4, pat, 0, 0, 6'd0, "R8 ones right code 0");
      send(3'd4, pat, 0, 0, 6'o77, "R8 ones right code 77");
      send(3'd4, pat, 0, 0, 6'd48, "R8 ones right 16 bits");
      send(3'd5, pat, 0, 0, 6'd0, "R9 ones left code 0");
      send(3'd5, pat, 0, 0, 6'd1, "R9 ones left 1");
      send(3'd5, pat, 0, 0, 6'd63, "R9 ones left 63");
      send(3'd6, pat, 0, 0, 6'd0, "R10 zeros left code 0");
      send(3'd6, pat, 0, 0, 6'd8, "R10 zeros left 8");
      send(3'd7, pat, 0, 0, 6'd0, "R11 zeros right code 0");
      send(3'd7, pat, 0, 0, 6'd56, "R11 zeros right 8");
      send(3'd7, pat, 0, 0, 6'o77, "R11 zeros right 1");
      idle(3);

      for (int i = 0; i < 600; i++) begin
         logic [2:0]  ro;
         logic [23:0] rc;
         string       rt;
         ro = 3'($urandom_range(0, 7));
         rc = ($urandom_range(0, 3) == 0) ? 24'($urandom) : 24'($urandom_range(0, 140));
         case (ro)
            3'd0: rt = "R1 random";
            3'd1: rt = "R2 random";
            3'd2: rt = "R3 random";
            3'd3: rt = "R4 random";
            3'd4: rt = "R8 random";
            3'd5: rt = "R9 random";
            3'd6: rt = "R10 random";
            default: rt = "R11 random";
         endcase
         send(ro, {$urandom, $urandom}, {$urandom, $urandom}, rc,
              6'($urandom), rt);
         if ($urandom_range(0, 4) == 0) idle(1);
      end
      idle(2);

      @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule